// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a byte-wide transmit stream from a ring of buffer descriptors that software keeps in a shared synchronous memory. Each descriptor is two 32-bit words. The first word carries a 16-bit status field in bits [31:16] and the frame length in bytes in bits [15:0]. The second word carries the word address of the frame buffer. The engine checks whether the current descriptor is owned by hardware. If it is, the engine reads the buffer and sends the bytes with first and last markers. It pads short frames on request and raises a CRC request flag for the downstream MAC. When the MAC reports that the frame is finished, the engine writes the status back and moves to the next ring entry.

Collision handling, backoff and CRC generation live in the MAC. The MAC reports the outcome of each frame on a status input: a retry count and three fatal error flags. Completion and error events are latched for the host, and the host clears them by writing 1. A fatal error freezes the ring until the host issues a restart. An idle ring is woken by a poll strobe.

Top module: `txbd_ring`

## Requirements
- R1: The engine transmits a descriptor only when status bit 15 (Ready) of its first word is 1. When the current descriptor is not Ready, the engine returns to idle, sends nothing and writes nothing. It reads that descriptor again only after a `poll` pulse.
- R2: Buffer bytes leave on `txData` in address order, lowest byte lane first: bits [7:0] of a word go before bits [15:8], and so on. `txValid` qualifies each byte. `txFirst` marks the first byte of a frame and `txLast` marks the final byte. Exactly one `txFirst` and one `txLast` appear per frame.
- R3: If status bit 14 (Pad) is 1 and the length is below `MIN_FRAME`, the frame is extended to `MIN_FRAME` bytes with `PAD_BYTE` (default 0x88). Otherwise exactly the length field's number of bytes is sent.
- R4: `txCrcReq` equals status bit 12 (CRC) on every byte of the frame.
- R5: After `macDone`, the first descriptor word is rewritten. Bit 15 is cleared. Bits 14:8, which include Wrap (bit 13), and the length field are kept unchanged. `macRetries` is written to bits [5:2], late collision to bit 7, retry limit exceeded to bit 6 and underrun to bit 1. Bit 0 is written as 0.
- R6: Descriptors are taken strictly in ring order, two words apart. After an entry with Wrap (bit 13) set, the engine returns to `RING_BASE`. A completed frame is followed by a fetch of the next descriptor with no poll needed.
- R7: `evtOut[0]` is set by every status write-back. `evtOut[1]` is set by a write-back that carries any error flag. Writing 1 to an `evtClr` bit clears the matching event. Setting takes priority over clearing in the same cycle.
- R8: After an error write-back, `halted` is 1 and no fetch happens, even on `poll`. A `restartCmd` pulse resumes processing at the descriptor that follows the failed one.
- R9: The memory port performs at most one access per cycle. Read data is taken one cycle after `memRe`.
- R10: After reset there is no stream output, no memory access, no event and no halt, and the ring pointer is at `RING_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Re-examine the current descriptor when idle |
| restartCmd | input | 1 | Leave the halted state |
| evtClr | input | 2 | Write-1-to-clear for the events |
| evtOut | output | 2 | [0] buffer done, [1] transmit error |
| halted | output | 1 | Ring stopped after an error |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | AW | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after memRe |
| txValid | output | 1 | Stream byte valid |
| txData | output | 8 | Stream byte |
| txFirst | output | 1 | First byte of frame |
| txLast | output | 1 | Last byte of frame |
| txCrcReq | output | 1 | MAC should append CRC |
| macDone | input | 1 | MAC finished the current frame |
| macRetries | input | 4 | Retries used for the frame |
| macLateColl | input | 1 | Late collision |
| macRetryLim | input | 1 | Retry limit exceeded |
| macUnderrun | input | 1 | Underrun |

## Verification
The assertions check properties that must hold on every cycle:
- Reads and writes to memory are exclusive.
- Every write-back clears Ready.
- The stream drops after each last byte.
- A halt persists until a restart and always comes with the error event.
- The buffer-done event only follows a write.

Only the bench scenarios can show the rest:
- Byte order, padding length and pad content.
- Field-accurate status merging.
- Ring order across the wrap.
- That a poll during a halt is ignored.
- That the engine resumes at the correct entry after a restart.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  // status field bit positions (within the upper half of word 0)
  localparam int ST_RDY  = 15;
  localparam int ST_PAD  = 14;
  localparam int ST_WRAP = 13;
  localparam int ST_CRC  = 12;
  localparam int ST_LC   = 7;
  localparam int ST_RL   = 6;
  localparam int ST_UN   = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_CK0, S_CK1, S_RDW, S_LDW, S_EMIT, S_WAITM, S_WB, S_HALT
  } engState_t;

  typedef enum logic [1:0] {A_DESC0, A_DESC1, A_DATA} addrSel_t;

  typedef struct packed {
    logic ldDesc0;
    logic ldDesc1;
    logic ldWord;
    logic stepByte;
    logic ldMac;
    logic wbDone;
  } ctlStrb_t;
endpackage

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
  import txbd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     poll,
  input  logic     restartCmd,
  input  logic     macDone,
  input  logic     descReady,
  input  logic     lenZero,
  input  logic     totZero,
  input  logic     isLast,
  input  logic     needWord,
  input  logic     errAny,
  output ctlStrb_t strb,
  output addrSel_t addrSel,
  output logic     memRe,
  output logic     memWe,
  output logic     txValid,
  output logic     halted
);
  engState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    addrSel   = A_DESC0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    halted    = 1'b0;
    case (state)
      S_IDLE: if (poll) nextState = S_RD0;
      S_RD0: begin
        memRe     = 1'b1;
        nextState = S_CK0;
      end
      S_CK0: begin
        if (descReady) begin
          strb.ldDesc0 = 1'b1;
          memRe        = 1'b1;
          addrSel      = A_DESC1;
          nextState    = S_CK1;
        end else begin
          nextState = S_IDLE;
        end
      end
      S_CK1: begin
        strb.ldDesc1 = 1'b1;
        if (!lenZero)    nextState = S_RDW;
        else if (totZero) nextState = S_WB;
        else             nextState = S_EMIT;
      end
      S_RDW: begin
        memRe     = 1'b1;
        addrSel   = A_DATA;
        nextState = S_LDW;
      end
      S_LDW: begin
        strb.ldWord = 1'b1;
        nextState   = S_EMIT;
      end
      S_EMIT: begin
        txValid       = 1'b1;
        strb.stepByte = 1'b1;
        if (isLast)        nextState = S_WAITM;
        else if (needWord) nextState = S_RDW;
      end
      S_WAITM: begin
        if (macDone) begin
          strb.ldMac = 1'b1;
          nextState  = S_WB;
        end
      end
      S_WB: begin
        memWe       = 1'b1;
        strb.wbDone = 1'b1;
        nextState   = errAny ? S_HALT : S_RD0;
      end
      S_HALT: begin
        halted = 1'b1;
        if (restartCmd) nextState = S_RD0;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/txbd_dpath.sv
module txbd_dpath
  import txbd_pkg::*;
#(
  parameter int AW        = 10,
  parameter int RING_BASE = 0,
  parameter int MIN_FRAME = 60,
  parameter logic [7:0] PAD_BYTE = 8'h88
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrb_t      strb,
  input  addrSel_t      addrSel,
  input  logic [31:0]   memRdata,
  input  logic [3:0]    macRetries,
  input  logic          macLateColl,
  input  logic          macRetryLim,
  input  logic          macUnderrun,
  input  logic [1:0]    evtClr,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [7:0]    txData,
  output logic          firstRaw,
  output logic          lastRaw,
  output logic          crcRaw,
  output logic          descReady,
  output logic          lenZero,
  output logic          totZero,
  output logic          isLast,
  output logic          needWord,
  output logic          errAny,
  output logic [1:0]    evtOut
);
  localparam logic [15:0] MinLen  = 16'(MIN_FRAME);
  localparam logic [15:0] ClrMask = 16'h80FF;

  logic [AW-1:0] descPtr, bufPtr;
  logic [15:0]   stsReg, lenReg, byteCnt, totLen, newSts;
  logic [31:0]   wordReg;
  logic [1:0]    lane;
  logic [3:0]    rtyReg;
  logic          lcReg, rlReg, unReg;
  logic [1:0]    evtReg;

  assign totLen   = (stsReg[ST_PAD] && lenReg < MinLen) ? MinLen : lenReg;
  assign descReady = memRdata[16+ST_RDY];
  assign lenZero  = (lenReg == 16'd0);
  assign totZero  = (totLen == 16'd0);
  assign isLast   = (byteCnt == totLen - 16'd1);
  assign needWord = (({1'b0, byteCnt} + 17'd1) < {1'b0, lenReg}) && (lane == 2'd3);
  assign errAny   = lcReg | rlReg | unReg;
  assign evtOut   = evtReg;

  assign txData   = (byteCnt < lenReg) ? wordReg[{lane, 3'b000} +: 8] : PAD_BYTE;
  assign firstRaw = (byteCnt == 16'd0);
  assign lastRaw  = isLast;
  assign crcRaw   = stsReg[ST_CRC];

  assign newSts   = (stsReg & ~ClrMask) |
                    {8'h00, lcReg, rlReg, rtyReg, unReg, 1'b0};
  assign memWdata = {newSts, lenReg};

  always_comb begin
    case (addrSel)
      A_DESC1: memAddr = descPtr + AW'(1);
      A_DATA:  memAddr = bufPtr;
      default: memAddr = descPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= AW'(RING_BASE);
      bufPtr  <= '0;
      stsReg  <= '0;
      lenReg  <= '0;
      byteCnt <= '0;
      wordReg <= '0;
      lane    <= '0;
      rtyReg  <= '0;
      lcReg   <= 1'b0;
      rlReg   <= 1'b0;
      unReg   <= 1'b0;
      evtReg  <= '0;
    end else begin
      if (strb.ldDesc0) begin
        stsReg <= memRdata[31:16];
        lenReg <= memRdata[15:0];
      end
      if (strb.ldDesc1) begin
        bufPtr  <= memRdata[AW-1:0];
        byteCnt <= '0;
        lane    <= '0;
        rtyReg  <= '0;
        lcReg   <= 1'b0;
        rlReg   <= 1'b0;
        unReg   <= 1'b0;
      end
      if (strb.ldWord) begin
        wordReg <= memRdata;
        bufPtr  <= bufPtr + AW'(1);
      end
      if (strb.stepByte) begin
        byteCnt <= byteCnt + 16'd1;
        lane    <= lane + 2'd1;
      end
      if (strb.ldMac) begin
        rtyReg <= macRetries;
        lcReg  <= macLateColl;
        rlReg  <= macRetryLim;
        unReg  <= macUnderrun;
      end
      if (strb.wbDone)
        descPtr <= stsReg[ST_WRAP] ? AW'(RING_BASE) : descPtr + AW'(2);
      evtReg <= (evtReg & ~evtClr) | {strb.wbDone & errAny, strb.wbDone};
    end
  end
endmodule

// File: rtl/txbd_ring.sv
module txbd_ring
  import txbd_pkg::*;
#(
  parameter int AW        = 10,
  parameter int RING_BASE = 0,
  parameter int MIN_FRAME = 60,
  parameter logic [7:0] PAD_BYTE = 8'h88
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          poll,
  input  logic          restartCmd,
  input  logic [1:0]    evtClr,
  output logic [1:0]    evtOut,
  output logic          halted,
  output logic          memRe,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          txValid,
  output logic [7:0]    txData,
  output logic          txFirst,
  output logic          txLast,
  output logic          txCrcReq,
  input  logic          macDone,
  input  logic [3:0]    macRetries,
  input  logic          macLateColl,
  input  logic          macRetryLim,
  input  logic          macUnderrun
);
  ctlStrb_t strb;
  addrSel_t addrSel;
  logic descReady, lenZero, totZero, isLast, needWord, errAny;
  logic firstRaw, lastRaw, crcRaw;

  txbd_ctrl ctrl_i (
    .clk, .rstN, .poll, .restartCmd, .macDone,
    .descReady, .lenZero, .totZero, .isLast, .needWord, .errAny,
    .strb, .addrSel, .memRe, .memWe, .txValid, .halted
  );

  txbd_dpath #(
    .AW(AW), .RING_BASE(RING_BASE), .MIN_FRAME(MIN_FRAME), .PAD_BYTE(PAD_BYTE)
  ) dpath_i (
    .clk, .rstN, .strb, .addrSel, .memRdata,
    .macRetries, .macLateColl, .macRetryLim, .macUnderrun, .evtClr,
    .memAddr, .memWdata, .txData, .firstRaw, .lastRaw, .crcRaw,
    .descReady, .lenZero, .totZero, .isLast, .needWord, .errAny, .evtOut
  );

  assign txFirst  = txValid & firstRaw;
  assign txLast   = txValid & lastRaw;
  assign txCrcReq = txValid & crcRaw;
endmodule

// File: rtl/txbd_ring_chk.sv
module txbd_ring_chk (
  input logic        clk,
  input logic        rstN,
  input logic        restartCmd,
  input logic [1:0]  evtOut,
  input logic        halted,
  input logic        memRe,
  input logic        memWe,
  input logic [31:0] memWdata,
  input logic        txValid,
  input logic        txFirst,
  input logic        txLast
);
  // R9
  mem_one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRe, memWe}));

  // R5
  wb_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memWdata[31]);

  // R2
  last_ends_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLast |=> !txValid);

  // R2
  first_is_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFirst |-> txValid);

  // R8
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !restartCmd) |=> halted);

  // R8
  halt_has_error_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> evtOut[1]);

  // R7
  done_evt_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtOut[0]) |-> $past(memWe));
endmodule

bind txbd_ring txbd_ring_chk chk_i (
  .clk(clk), .rstN(rstN), .restartCmd(restartCmd), .evtOut(evtOut),
  .halted(halted), .memRe(memRe), .memWe(memWe), .memWdata(memWdata),
  .txValid(txValid), .txFirst(txFirst), .txLast(txLast)
);

// File: tb/txbd_ring_tb.sv
`timescale 1ns/1ps
module txbd_ring_tb_top;
  localparam int AW = 10;
  localparam int MINF = 60;
  localparam int NF = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic poll = 0, restartCmd = 0;
  logic [1:0] evtClr = '0, evtOut;
  logic halted, memRe, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic txValid, txFirst, txLast, txCrcReq;
  logic [7:0] txData;
  logic macDone = 0, macLateColl = 0, macRetryLim = 0, macUnderrun = 0;
  logic [3:0] macRetries = '0;

  txbd_ring #(.AW(AW)) dut_i (.*);

  // bench memory with a host write port
  logic [31:0] mem [0:(1<<AW)-1];
  logic hostWe = 0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    else if (hostWe) mem[hostAddr] <= hostData;
    if (memRe) memRdata <= mem[memAddr];
  end

  int total = 0, bad = 0;
  int planF = 0, frameNo = 0, capCnt = 0, macIdx = 0;
  logic [7:0] expB [0:NF-1][0:127];
  logic [7:0] capB [0:NF-1][0:127];
  int expLen [0:NF-1], expTot [0:NF-1], expDesc [0:NF-1], capLen [0:NF-1];
  bit expCrc [0:NF-1], capFlagBad [0:NF-1], capCrcBad [0:NF-1];
  logic [31:0] expWb [0:NF-1];
  logic [3:0] planRty [0:NF-1];
  bit planLc [0:NF-1], planRl [0:NF-1], planUn [0:NF-1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream monitor
  always @(negedge clk) begin
    if (!rstN) begin
      capCnt = 0;
      for (int i = 0; i < NF; i++) begin capFlagBad[i] = 0; capCrcBad[i] = 0; capLen[i] = 0; end
    end else if (txValid && frameNo < NF) begin
      if (capCnt < 128) capB[frameNo][capCnt] = txData;
      if ((capCnt == 0) != txFirst) capFlagBad[frameNo] = 1;
      if (txCrcReq != expCrc[frameNo]) capCrcBad[frameNo] = 1;
      capCnt++;
      if (txLast) begin capLen[frameNo] = capCnt; frameNo++; capCnt = 0; end
    end
  end

  // MAC status responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txValid && txLast) begin
        repeat (1 + $urandom % 5) @(negedge clk);
        macDone = 1;
        macRetries = planRty[macIdx];
        macLateColl = planLc[macIdx];
        macRetryLim = planRl[macIdx];
        macUnderrun = planUn[macIdx];
        macIdx++;
        @(negedge clk);
        macDone = 0; macRetries = '0;
        macLateColl = 0; macRetryLim = 0; macUnderrun = 0;
      end
    end
  end

  task automatic hw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic pulsePoll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic pulseRestart();
    @(negedge clk); restartCmd = 1;
    @(negedge clk); restartCmd = 0;
  endtask

  task automatic clearEvt(input logic [1:0] m);
    @(negedge clk); evtClr = m;
    @(negedge clk); evtClr = '0;
  endtask

  function automatic int totLen(input int len, input bit pad);
    return (pad && len < MINF) ? MINF : len;
  endfunction

  task automatic prepDesc(input int d, input int len, input bit pad, input bit crc,
                          input logic [3:0] rty, input bit lc, input bit rl, input bit un);
    int f;
    logic [AW-1:0] base;
    logic [3:0] other;
    logic [15:0] sts;
    f = planF;
    base = AW'(256 + 32 * d);
    for (int k = 0; k < 128; k++) expB[f][k] = 8'($urandom);
    for (int w = 0; w < (len + 3) / 4; w++)
      hw(base + AW'(w), {expB[f][4*w+3], expB[f][4*w+2], expB[f][4*w+1], expB[f][4*w]});
    other = 4'($urandom);
    sts = {1'b1, pad, d == 3, crc, other, 8'($urandom)};
    expLen[f] = len; expTot[f] = totLen(len, pad); expCrc[f] = crc; expDesc[f] = d;
    planRty[f] = rty; planLc[f] = lc; planRl[f] = rl; planUn[f] = un;
    expWb[f] = {1'b0, pad, d == 3, crc, other, lc, rl, rty, un, 1'b0, 16'(len)};
    planF++;
    hw(AW'(2 * d + 1), 32'(base));
    hw(AW'(2 * d), {sts, 16'(len)});
  endtask

  task automatic waitFrames(input int n);
    int guard = 0;
    while (frameNo < n && guard < 20000) begin @(negedge clk); guard++; end
    repeat (14) @(negedge clk);
  endtask

  task automatic checkFrame(input int f);
    int mism = 0;
    logic [7:0] e;
    chk(capLen[f] == expTot[f], "R3 frame length", capLen[f], expTot[f]);
    for (int k = 0; k < expTot[f]; k++) begin
      e = (k < expLen[f]) ? expB[f][k] : 8'h88;
      if (capB[f][k] !== e) mism++;
    end
    chk(mism == 0, "R2 R3 frame bytes mismatch count", mism, 0);
    chk(!capFlagBad[f], "R2 first marker", capFlagBad[f], 0);
    chk(!capCrcBad[f], "R4 crc request", capCrcBad[f], 0);
    chk(mem[2*expDesc[f]] === expWb[f], "R5 status write-back", mem[2*expDesc[f]], expWb[f]);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ptr, nb, f0;
    bit errLast;
    logic [31:0] snap;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk(!txValid, "R10 txValid after reset", txValid, 0);
    chk(!halted, "R10 halted after reset", halted, 0);
    chk(evtOut == 2'b00, "R10 events after reset", evtOut, 0);
    chk(!memRe && !memWe, "R10 memory idle after reset", {memRe, memWe}, 0);

    // R1 not-ready descriptor: nothing happens
    hw(AW'(1), 32'd256);
    hw(AW'(0), 32'h0000_0010);
    pulsePoll();
    repeat (30) @(negedge clk);
    chk(frameNo == 0, "R1 no frame from non-ready descriptor", frameNo, 0);
    chk(mem[0] == 32'h0000_0010, "R1 non-ready descriptor untouched", mem[0], 32'h10);

    // directed batch across the whole ring
    prepDesc(0, 5, 1, 1, 4'd0, 0, 0, 0);
    prepDesc(1, 1, 0, 0, 4'd15, 0, 0, 0);
    prepDesc(2, 70, 1, 1, 4'd7, 0, 0, 0);
    prepDesc(3, MINF - 1, 0, 0, 4'd2, 0, 0, 0);
    pulsePoll();
    waitFrames(4);
    for (int f = 0; f < 4; f++) checkFrame(f);
    chk(frameNo == 4, "R6 ring stops at non-ready entry after wrap", frameNo, 4);
    chk(evtOut == 2'b01, "R7 done event only", evtOut, 2'b01);
    clearEvt(2'b01);
    @(negedge clk);
    chk(evtOut == 2'b00, "R7 write-1 clear", evtOut, 0);

    // wrap back to entry 0, then an error on entry 1
    prepDesc(0, 9, 0, 1, 4'd1, 0, 0, 0);
    prepDesc(1, 33, 1, 0, 4'd3, 1, 0, 0);
    pulsePoll();
    waitFrames(6);
    checkFrame(4);
    checkFrame(5);
    chk(expDesc[4] == 0, "R6 frame after wrap from ring base", expDesc[4], 0);
    chk(halted, "R8 halted after error", halted, 1);
    chk(evtOut == 2'b11, "R7 error event", evtOut, 2'b11);
    prepDesc(2, 12, 0, 0, 4'd0, 0, 0, 0);
    pulsePoll();
    repeat (40) @(negedge clk);
    chk(frameNo == 6, "R8 poll ignored while halted", frameNo, 6);
    snap = mem[4];
    chk(snap[31], "R8 next entry still owned by hardware", snap[31], 1);
    pulseRestart();
    waitFrames(7);
    checkFrame(6);
    chk(!halted, "R8 restart leaves halt", halted, 0);
    clearEvt(2'b11);
    ptr = 3;

    // constrained random batches
    for (int r = 0; r < 8; r++) begin
      nb = 1 + $urandom % 3;
      errLast = ($urandom % 3) == 0;
      f0 = planF;
      for (int j = 0; j < nb; j++) begin
        bit e;
        int sel;
        e = errLast && (j == nb - 1);
        sel = $urandom % 3;
        prepDesc(ptr, 1 + $urandom % 90, 1'($urandom), 1'($urandom), 4'($urandom),
                 e && sel == 0, e && sel == 1, e && sel == 2);
        ptr = (ptr + 1) % 4;
      end
      pulsePoll();
      waitFrames(planF);
      for (int f = f0; f < planF; f++) checkFrame(f);
      chk(evtOut == {errLast, 1'b1}, "R7 events after batch", evtOut, {errLast, 1'b1});
      chk(halted == errLast, "R8 halt follows error", halted, errLast);
      if (errLast) pulseRestart();
      clearEvt(2'b11);
      repeat (4) @(negedge clk);
      chk(!halted && evtOut == 2'b00, "R8 R7 clean after restart and clear", {halted, evtOut}, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule